// File: doc/BRIEF.md
# Multi-cycle floating-point hazard interlock

This block sits in the decode stage of an in-order pipeline that feeds three floating-point units. The adder is pipelined and takes four cycles. The multiplier takes four cycles and the divider takes six, and neither of those two is pipelined. Each cycle the block looks at the decoded instruction: its operation code, destination register, two source registers and a valid flag. It then either holds the instruction in decode or launches it to one unit. An instruction that is held blocks everything behind it, so instructions leave decode in program order. Results may still come back out of order, because the units have different latencies.

The block models the units only as latency counters and carries no operand data. It keeps three pieces of state. A per-register busy vector marks every destination that is still in flight. A reservation line indexed by cycles-from-now tracks the single write-back port. One flag per non-pipelined unit shows whether that unit is occupied. Each cycle it reports the write-back that completes in that cycle, if any, together with the destination register tag, so that the rest of the pipeline can retire the result.

Top module: `fp_hazard_interlock`

## Requirements
- R1: While reset is active and in the first cycle after it, `stall`, `launch`, every unit select and `wb_valid` are 0, and no register is busy.
- R2: Operation code 00 selects the adder, 01 the multiplier, and 10 or 11 the divider. `launch` and `stall` are both 0 when `id_valid` is 0. When `id_valid` is 1, exactly one of them is 1. When `launch` is 1, exactly the unit select that matches the operation code is 1.
- R3: An instruction launched in cycle t produces `wb_valid`=1 with `wb_dst` equal to its destination in cycle t+4 (adder or multiplier) or in cycle t+6 (divider).
- R4: The adder accepts a new instruction in every cycle. Adder launches are never stalled because another adder operation is in flight.
- R5: A multiply is stalled while an earlier multiply is in flight, and a divide is stalled while an earlier divide is in flight. In the cycle in which the occupying operation writes back, a new operation of the same kind may launch.
- R6: No two instructions write back in the same cycle. An instruction whose write-back cycle is already reserved is stalled.
- R7: An instruction is stalled while either of its source registers is the destination of an in-flight instruction, including one that writes back in the current cycle.
- R8: An instruction is stalled while its destination register is the destination of an in-flight instruction.
- R9: A stalled instruction is not launched. Because no later instruction can reach the block until it leaves, program order is kept at launch.
- R10: Instructions that write different registers may write back in an order different from their launch order. For example, an add launched one cycle after a divide writes back first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode holds an instruction |
| id_op | input | 2 | Operation code: 00 add, 01 multiply, 1x divide |
| id_dst | input | $clog2(NREG) | Destination register |
| id_src_a | input | $clog2(NREG) | First source register |
| id_src_b | input | $clog2(NREG) | Second source register |
| stall | output | 1 | Hold the instruction in decode this cycle |
| launch | output | 1 | The instruction leaves decode this cycle |
| sel_add | output | 1 | Launch goes to the adder |
| sel_mul | output | 1 | Launch goes to the multiplier |
| sel_div | output | 1 | Launch goes to the divider |
| wb_valid | output | 1 | A result writes back this cycle |
| wb_dst | output | $clog2(NREG) | Destination register of that result |

## Verification
The hardest case to reach from the ports is a write-back collision. It only appears when a long-latency launch is followed, after exactly the latency difference, by a shorter one that would land in the same cycle. The test produces it on purpose with a divide, one idle cycle, and then an add, and again with a divide followed two cycles later by a multiply. A long pseudo-random stream over only eight registers then mixes RAW, WAW, structural and collision stalls in many overlapping combinations. That stream also covers the cycle in which a unit frees itself and a dependent instruction is still blocked.

// File: rtl/fp_hazard_interlock.sv
module fp_hazard_interlock #(
  parameter int NREG    = 32,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 4,
  parameter int DIV_LAT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    id_valid,
  input  logic [1:0]              id_op,
  input  logic [$clog2(NREG)-1:0] id_dst,
  input  logic [$clog2(NREG)-1:0] id_src_a,
  input  logic [$clog2(NREG)-1:0] id_src_b,
  output logic                    stall,
  output logic                    launch,
  output logic                    sel_add,
  output logic                    sel_mul,
  output logic                    sel_div,
  output logic                    wb_valid,
  output logic [$clog2(NREG)-1:0] wb_dst
);
  localparam int RW   = $clog2(NREG);
  localparam int MAXL = (DIV_LAT > MUL_LAT) ? ((DIV_LAT > ADD_LAT) ? DIV_LAT : ADD_LAT)
                                            : ((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT);
  localparam int LW   = $clog2(MAXL + 1);

  logic [MAXL:0]   slot_v;
  logic [RW-1:0]   slot_tag [MAXL:0];
  logic [MAXL:0]   slot_mul;
  logic [MAXL:0]   slot_div;
  logic [NREG-1:0] busy;
  logic            mul_busy, div_busy;

  logic            is_div, is_mul, is_add;
  logic [LW-1:0]   lat, lat_m1;
  logic            wb_is_mul, wb_is_div;
  logic            unit_blocked, slot_taken, raw, waw;

  assign is_div = id_op[1];
  assign is_mul = (id_op == 2'b01);
  assign is_add = (id_op == 2'b00);
  assign lat    = is_div ? LW'(DIV_LAT) : (is_mul ? LW'(MUL_LAT) : LW'(ADD_LAT));
  assign lat_m1 = lat - LW'(1);

  assign wb_is_mul = slot_v[0] & slot_mul[0];
  assign wb_is_div = slot_v[0] & slot_div[0];

  assign unit_blocked = (is_mul & mul_busy & ~wb_is_mul) | (is_div & div_busy & ~wb_is_div);
  assign slot_taken   = slot_v[lat];
  assign raw          = busy[id_src_a] | busy[id_src_b];
  assign waw          = busy[id_dst];

  assign stall   = id_valid & (raw | waw | unit_blocked | slot_taken);
  assign launch  = id_valid & ~stall;
  assign sel_add = launch & is_add;
  assign sel_mul = launch & is_mul;
  assign sel_div = launch & is_div;

  assign wb_valid = slot_v[0];
  assign wb_dst   = slot_tag[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v   <= '0;
      slot_mul <= '0;
      slot_div <= '0;
      for (int k = 0; k <= MAXL; k++) slot_tag[k] <= '0;
    end else begin
      for (int k = 0; k < MAXL; k++) begin
        slot_v[k]   <= slot_v[k+1];
        slot_mul[k] <= slot_mul[k+1];
        slot_div[k] <= slot_div[k+1];
        slot_tag[k] <= slot_tag[k+1];
      end
      slot_v[MAXL]   <= 1'b0;
      slot_mul[MAXL] <= 1'b0;
      slot_div[MAXL] <= 1'b0;
      slot_tag[MAXL] <= '0;
      if (launch) begin
        slot_v[lat_m1]   <= 1'b1;
        slot_mul[lat_m1] <= is_mul;
        slot_div[lat_m1] <= is_div;
        slot_tag[lat_m1] <= id_dst;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= '0;
      mul_busy <= 1'b0;
      div_busy <= 1'b0;
    end else begin
      busy <= (busy & ~((NREG'(slot_v[0])) << slot_tag[0]))
            | ((NREG'(launch)) << id_dst);
      if (launch & is_mul)  mul_busy <= 1'b1;
      else if (wb_is_mul)   mul_busy <= 1'b0;
      if (launch & is_div)  div_busy <= 1'b1;
      else if (wb_is_div)   div_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_hazard_interlock_chk.sv
module fp_hazard_interlock_chk #(
  parameter int MUL_LAT = 4,
  parameter int DIV_LAT = 6
) (
  input logic clk,
  input logic rst_n,
  input logic id_valid,
  input logic stall,
  input logic launch,
  input logic sel_add,
  input logic sel_mul,
  input logic sel_div,
  input logic wb_valid
);
  int mul_age, div_age, outstanding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_age     <= MUL_LAT;
      div_age     <= DIV_LAT;
      outstanding <= 0;
    end else begin
      if (launch && sel_mul)     mul_age <= 1;
      else if (mul_age < MUL_LAT) mul_age <= mul_age + 1;
      if (launch && sel_div)     div_age <= 1;
      else if (div_age < DIV_LAT) div_age <= div_age + 1;
      outstanding <= outstanding + (launch ? 1 : 0) - (wb_valid ? 1 : 0);
    end
  end

  // R2
  launch_xor_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (launch ^ stall));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !(launch || stall));

  // R2
  one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ($countones({sel_add, sel_mul, sel_div}) == 1));

  // R5
  mul_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel_mul) |-> (mul_age >= MUL_LAT));

  // R5
  div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel_div) |-> (div_age >= DIV_LAT));

  // R3
  wb_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (outstanding > 0));
endmodule

bind fp_hazard_interlock fp_hazard_interlock_chk #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .stall(stall), .launch(launch),
  .sel_add(sel_add), .sel_mul(sel_mul), .sel_div(sel_div), .wb_valid(wb_valid)
);

// File: tb/fp_hazard_interlock_bench.sv
`timescale 1ns/1ps
module fp_hazard_interlock_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       id_valid = 0;
  logic [1:0] id_op = 0;
  logic [4:0] id_dst = 0, id_src_a = 0, id_src_b = 0;
  logic       stall, launch, sel_add, sel_mul, sel_div, wb_valid;
  logic [4:0] wb_dst;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc = 0;
  int q_dst[$], q_unit[$], q_wb[$];
  bit last_launch;

  always #2.5 clk = ~clk;

  fp_hazard_interlock u_fp_hazard_interlock (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op), .id_dst(id_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .stall(stall), .launch(launch),
    .sel_add(sel_add), .sel_mul(sel_mul), .sel_div(sel_div),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic cycle(input bit v, input int op, input int d, input int a, input int b);
    int unit, lat, exp_wbd;
    bit exp_wb, r_raw, r_waw, r_unit, r_coll, exp_stall, exp_launch;
    string tag;
    @(negedge clk);
    id_valid = v; id_op = op[1:0]; id_dst = d[4:0]; id_src_a = a[4:0]; id_src_b = b[4:0];
    #1;
    unit = (op >= 2) ? 2 : op;
    lat  = (unit == 2) ? 6 : 4;
    exp_wb = 0; exp_wbd = 0; r_raw = 0; r_waw = 0; r_unit = 0; r_coll = 0;
    foreach (q_dst[i]) begin
      if (q_wb[i] == cyc) begin exp_wb = 1; exp_wbd = q_dst[i]; end
      if (q_dst[i] == a || q_dst[i] == b) r_raw = 1;
      if (q_dst[i] == d) r_waw = 1;
      if (unit != 0 && q_unit[i] == unit && q_wb[i] != cyc) r_unit = 1;
      if (q_wb[i] == cyc + lat) r_coll = 1;
    end
    exp_stall  = v && (r_raw || r_waw || r_unit || r_coll);
    exp_launch = v && !exp_stall;
    if (!v)          tag = "R2";
    else if (r_raw)  tag = "R7 R9";
    else if (r_waw)  tag = "R8 R9";
    else if (r_unit) tag = "R5";
    else if (r_coll) tag = "R6";
    else             tag = (unit == 0) ? "R4 R2" : "R5 R2";
    chk(tag, "stall", stall, exp_stall);
    chk(tag, "launch", launch, exp_launch);
    chk("R2", "sel_add", sel_add, exp_launch && unit == 0);
    chk("R2", "sel_mul", sel_mul, exp_launch && unit == 1);
    chk("R2", "sel_div", sel_div, exp_launch && unit == 2);
    chk("R3 R10", "wb_valid", wb_valid, exp_wb);
    if (exp_wb) chk("R3 R10", "wb_dst", wb_dst, exp_wbd);
    @(posedge clk);
    for (int i = q_dst.size() - 1; i >= 0; i--)
      if (q_wb[i] == cyc) begin q_dst.delete(i); q_unit.delete(i); q_wb.delete(i); end
    if (exp_launch) begin q_dst.push_back(d); q_unit.push_back(unit); q_wb.push_back(cyc + lat); end
    last_launch = exp_launch;
    cyc++;
  endtask

  task automatic issue(input int op, input int d, input int a, input int b);
    for (int n = 0; n < 40; n++) begin
      cycle(1, op, d, a, b);
      if (last_launch) break;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #12;
    chk("R1", "reset stall", stall, 0);
    chk("R1", "reset launch", launch, 0);
    chk("R1", "reset wb_valid", wb_valid, 0);
    @(negedge clk);
    rst_n = 1;
    // R1: register 0 free right after reset
    cycle(1, 0, 1, 0, 0);
    idle(6);
    // R4: back-to-back adds
    for (int i = 0; i < 4; i++) issue(0, 10 + i, 1, 2);
    idle(6);
    // R5: multiply then multiply, divide then divide
    issue(1, 3, 1, 2); issue(1, 4, 1, 2);
    idle(6);
    issue(2, 5, 1, 2); issue(3, 6, 1, 2);
    idle(8);
    // R7 and R9: dependent add blocks independent multiply; R10 out-of-order
    issue(2, 0, 2, 4); issue(0, 10, 0, 8); issue(1, 12, 8, 14);
    idle(8);
    issue(2, 20, 2, 4); issue(0, 21, 2, 4);
    idle(8);
    // R8: same destination
    issue(2, 3, 1, 2); issue(0, 3, 5, 6);
    idle(8);
    // R6: collisions on the write-back port
    issue(2, 7, 1, 2); idle(1); issue(0, 8, 1, 2);
    idle(8);
    issue(2, 7, 1, 2); idle(1); issue(1, 9, 1, 2);
    idle(8);
    // R2: invalid slot with conflicting registers is neither stalled nor launched
    issue(2, 2, 1, 1); cycle(0, 2, 2, 2, 2); cycle(0, 1, 2, 2, 2);
    idle(8);
    // mixed stream over few registers
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      else issue($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
    end
    idle(10);
    finish_run();
  end
endmodule